// File: doc/BRIEF.md
# Threshold Priority Interrupt Selector

This block picks which interrupt source, if any, should be presented to one interrupt target context. Each source has three status bits (pending, claimed, enabled-for-this-context) and a priority value. The context has a threshold. A source may compete only if it is pending, enabled and not claimed. It wins only if its priority is strictly above the threshold and strictly above every lower-numbered competitor.

The result is the identifier of the winning source, plus a request flag for the context. Identifier zero is reserved and means "nothing to service". Source 0 can never be selected, whatever its inputs are.

The selection is a balanced comparison tree over (identifier, priority) pairs, and its result is captured in one register stage. The outputs therefore describe the inputs that were present at the previous rising clock edge.

Top module: `thresh_irq_pick`

## Requirements
- R1: A source is a candidate only when its `src_pend` bit is 1, its `src_ena` bit is 1 and its `src_clm` bit is 0; a source lacking any of these is never selected.
- R2: A candidate is selectable only when its priority is strictly greater than `ctx_thresh`; a priority equal to the threshold never produces a request.
- R3: Among selectable sources, the one with the highest priority is reported; source i's priority is `src_prio[i*PRIO_W +: PRIO_W]`, an unsigned value.
- R4: When several selectable sources share the highest priority, the lowest identifier is reported.
- R5: When no source is selectable, `win_id` is 0 and `irq_req` is 0.
- R6: `irq_req` is 1 exactly when `win_id` is nonzero.
- R7: Source 0 is never selected, even when it is pending, enabled, unclaimed and at maximum priority.
- R8: `win_id` and `irq_req` reflect the inputs sampled at the previous rising edge of `clk`, so there is exactly one cycle of latency.
- R9: While `rst_n` is 0, `win_id` and `irq_req` are 0.
- R10: A priority of 0 never wins, because the threshold is never below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pend | input | NUM_SRC | Pending bit of each source |
| src_clm | input | NUM_SRC | Claimed (in service) bit of each source |
| src_ena | input | NUM_SRC | Enable bit of each source for this context |
| src_prio | input | NUM_SRC*PRIO_W | Packed priorities; source i at bits i*PRIO_W upward |
| ctx_thresh | input | PRIO_W | Context threshold |
| win_id | output | ID_W | Registered identifier of the winner, 0 for none |
| irq_req | output | 1 | Registered request to the context |

## Verification
The bench aims at the places where a selector usually goes wrong.

- **Threshold equality:** a design that compares with "greater or equal" raises a request for a source sitting exactly at the threshold.
- **Ties:** a tree node that prefers its right input reports the highest tied identifier rather than the lowest.
- **Source 0:** forgetting to mask it returns identifier 0 while the request is high.
- **Claimed bit:** ignoring it reselects a source that is already in service.
- **Latency:** a missing or doubled register stage shows up as outputs that change one cycle early or late.

A long run of random vectors is then scored against a straightforward linear scan from the lowest identifier upward.

// File: rtl/thresh_pick_pkg.sv
package thresh_pick_pkg;

    // Smallest power of two that is not below n (n >= 1).
    function automatic int unsigned pow2_ceil(input int unsigned n);
        int unsigned r;
        r = 1;
        while (r < n) r = r << 1;
        return r;
    endfunction

endpackage

// File: rtl/src_qualify.sv
module src_qualify #(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned PRIO_W  = 3
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC-1:0]        clm,
    input  logic [NUM_SRC-1:0]        ena,
    input  logic [NUM_SRC*PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         thresh,
    output logic [NUM_SRC-1:0]        cand
);
    localparam logic [NUM_SRC-1:0] SRC0_BLOCK = {{(NUM_SRC-1){1'b1}}, 1'b0};

    logic [NUM_SRC-1:0] raw;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign raw[i] = pend[i] & ena[i] & ~clm[i]
                        & (prio[i*PRIO_W +: PRIO_W] > thresh);
    end

    // Identifier 0 is reserved: that source is treated as never pending.
    assign cand = raw & SRC0_BLOCK;
endmodule

// File: rtl/pick_tree.sv
module pick_tree
    import thresh_pick_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned ID_W    = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        cand,
    input  logic [NUM_SRC*PRIO_W-1:0] prio,
    output logic                      best_ok,
    output logic [ID_W-1:0]           best_id,
    output logic [PRIO_W-1:0]         best_prio
);
    localparam int unsigned LEAVES = pow2_ceil(NUM_SRC);
    localparam int unsigned LEVELS = $clog2(LEAVES);

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int unsigned CNT = LEAVES >> l;
        logic [CNT-1:0]        v;
        logic [CNT*ID_W-1:0]   id;
        logic [CNT*PRIO_W-1:0] p;

        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < CNT; i++) begin : g_in
                if (i < NUM_SRC) begin : g_real
                    assign v[i]                 = cand[i];
                    assign id[i*ID_W +: ID_W]   = ID_W'(i);
                    assign p[i*PRIO_W +: PRIO_W] = prio[i*PRIO_W +: PRIO_W];
                end else begin : g_pad
                    assign v[i]                 = 1'b0;
                    assign id[i*ID_W +: ID_W]   = '0;
                    assign p[i*PRIO_W +: PRIO_W] = '0;
                end
            end
        end else begin : g_merge
            for (genvar j = 0; j < CNT; j++) begin : g_node
                logic                lv, rv, take_r;
                logic [PRIO_W-1:0]   lp, rp;
                assign lv = g_lvl[l-1].v[2*j];
                assign rv = g_lvl[l-1].v[2*j+1];
                assign lp = g_lvl[l-1].p[(2*j)*PRIO_W +: PRIO_W];
                assign rp = g_lvl[l-1].p[(2*j+1)*PRIO_W +: PRIO_W];
                // Right (higher identifiers) wins only on a strictly larger priority.
                assign take_r = rv & (~lv | (rp > lp));
                assign v[j] = lv | rv;
                assign id[j*ID_W +: ID_W] = take_r ? g_lvl[l-1].id[(2*j+1)*ID_W +: ID_W]
                                                   : g_lvl[l-1].id[(2*j)*ID_W +: ID_W];
                assign p[j*PRIO_W +: PRIO_W] = take_r ? rp : lp;
            end
        end
    end

    assign best_ok   = g_lvl[LEVELS].v[0];
    assign best_id   = g_lvl[LEVELS].id[ID_W-1:0];
    assign best_prio = g_lvl[LEVELS].p[PRIO_W-1:0];
endmodule

// File: rtl/thresh_irq_pick.sv
module thresh_irq_pick #(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned ID_W    = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_pend,
    input  logic [NUM_SRC-1:0]        src_clm,
    input  logic [NUM_SRC-1:0]        src_ena,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic [PRIO_W-1:0]         ctx_thresh,
    output logic [ID_W-1:0]           win_id,
    output logic                      irq_req
);
    logic [NUM_SRC-1:0] cand;
    logic               best_ok;
    logic [ID_W-1:0]    best_id;
    logic [PRIO_W-1:0]  best_prio;

    src_qualify #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_qual (
        .pend   (src_pend),
        .clm    (src_clm),
        .ena    (src_ena),
        .prio   (src_prio),
        .thresh (ctx_thresh),
        .cand   (cand)
    );

    pick_tree #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_tree (
        .cand      (cand),
        .prio      (src_prio),
        .best_ok   (best_ok),
        .best_id   (best_id),
        .best_prio (best_prio)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_id  <= '0;
            irq_req <= 1'b0;
        end else begin
            win_id  <= best_ok ? best_id : '0;
            irq_req <= best_ok;
        end
    end

    // R1: the tree's winner satisfies the pending/enable/not-claimed rule
    a_r1_winner_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        best_ok |-> (src_pend[best_id] && src_ena[best_id] && !src_clm[best_id]));

    // R2: the tree's winner lies strictly above the threshold
    a_r2_above_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        best_ok |-> (best_prio > ctx_thresh));

    // R5: no candidate at the previous edge gives a zero identifier now
    a_r5_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(|cand) |-> (win_id == '0));

    // R6: the request flag tracks a nonzero identifier
    a_r6_req_matches_id: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (win_id != '0));

    // R7: source 0 is never reported by the tree
    a_r7_no_src0: assert property (@(posedge clk) disable iff (!rst_n)
        best_ok |-> (best_id != '0));
endmodule

// File: tb/thresh_irq_pick_test.sv
`timescale 1ns/1ps
module thresh_irq_pick_test;
    localparam int N = 16;
    localparam int W = 3;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   pend = '0, clm = '0, ena = '0;
    logic [N*W-1:0] prio = '0;
    logic [W-1:0]   thr = '0;
    logic [IW-1:0]  win_id;
    logic           irq_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    thresh_irq_pick #(.NUM_SRC(N), .PRIO_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .src_pend(pend), .src_clm(clm),
        .src_ena(ena), .src_prio(prio), .ctx_thresh(thr),
        .win_id(win_id), .irq_req(irq_req)
    );

    // Linear scan from the lowest identifier, replacing only on strictly higher priority.
    function automatic int ref_pick();
        int best = 0;
        int bp = int'(thr);
        for (int i = 1; i < N; i++) begin
            if (pend[i] && ena[i] && !clm[i] && int'(prio[i*W +: W]) > bp) begin
                best = i;
                bp = int'(prio[i*W +: W]);
            end
        end
        return best;
    endfunction

    task automatic expect_out(string req, int exp_id);
        total++;
        if (int'(win_id) != exp_id) begin
            bad++;
            $display("FAIL %s win_id actual=%0d expected=%0d", req, win_id, exp_id);
        end
        total++;
        if (irq_req != (exp_id != 0)) begin
            bad++;
            $display("FAIL %s irq_req actual=%0d expected=%0d", req, irq_req, exp_id != 0);
        end
    endtask

    // Inputs are already set; let one edge capture them and compare with the scan.
    task automatic step_check(string req);
        int e;
        e = ref_pick();
        @(posedge clk); #1;
        expect_out(req, e);
    endtask

    task automatic clear_all();
        pend = '0; clm = '0; ena = '0; prio = '0; thr = '0;
    endtask

    task automatic set_src(int i, logic p, logic e, logic c, int pr);
        pend[i] = p; ena[i] = e; clm[i] = c; prio[i*W +: W] = W'(pr);
    endtask

    task automatic t_reset();
        set_src(4, 1, 1, 0, 7);
        @(posedge clk); #1;
        expect_out("R9", 0);
        @(posedge clk); #1;
        expect_out("R9", 0);
        clear_all();
        rst_n = 1'b1;
        step_check("R9");
    endtask

    task automatic t_mask();
        clear_all();
        set_src(5, 1, 0, 0, 7); step_check("R1");
        if (win_id != 0) begin end
        set_src(5, 1, 1, 1, 7); step_check("R1");
        set_src(5, 0, 1, 0, 7); step_check("R1");
        set_src(5, 1, 1, 0, 7); step_check("R1");
        expect_out("R1", 5);
    endtask

    task automatic t_thresh();
        clear_all();
        set_src(9, 1, 1, 0, 4);
        thr = 3'd4; step_check("R2");
        expect_out("R2", 0);
        thr = 3'd3; step_check("R2");
        expect_out("R2", 9);
        thr = 3'd7; set_src(9, 1, 1, 0, 7); step_check("R2");
        expect_out("R2", 0);
    endtask

    task automatic t_max();
        clear_all();
        set_src(2, 1, 1, 0, 3);
        set_src(7, 1, 1, 0, 6);
        set_src(14, 1, 1, 0, 5);
        set_src(11, 1, 1, 1, 7);
        step_check("R3");
        expect_out("R3", 7);
        set_src(15, 1, 1, 0, 7);
        step_check("R3");
        expect_out("R3", 15);
    endtask

    task automatic t_tie();
        clear_all();
        set_src(12, 1, 1, 0, 6);
        set_src(9, 1, 1, 0, 6);
        set_src(3, 1, 1, 0, 6);
        step_check("R4");
        expect_out("R4", 3);
        set_src(3, 1, 1, 1, 6);
        step_check("R4");
        expect_out("R4", 9);
    endtask

    task automatic t_none();
        clear_all();
        pend = '1; ena = '1; clm = '1;
        for (int i = 0; i < N; i++) prio[i*W +: W] = 3'd5;
        step_check("R5");
        expect_out("R5", 0);
    endtask

    task automatic t_src0();
        clear_all();
        set_src(0, 1, 1, 0, 7);
        step_check("R7");
        expect_out("R7", 0);
        set_src(15, 1, 1, 0, 1);
        step_check("R7");
        expect_out("R7", 15);
    endtask

    task automatic t_zero_prio();
        clear_all();
        pend = '1; ena = '1;
        step_check("R10");
        expect_out("R10", 0);
    endtask

    task automatic t_latency();
        clear_all();
        set_src(6, 1, 1, 0, 2);
        step_check("R8");
        // Change inputs after the edge: outputs must hold until the next edge.
        set_src(10, 1, 1, 0, 5);
        #1;
        expect_out("R8", 6);
        @(posedge clk); #1;
        expect_out("R8", 10);
    endtask

    task automatic t_random();
        for (int k = 0; k < 400; k++) begin
            pend = N'($urandom);
            ena  = N'($urandom) | N'($urandom);
            clm  = N'($urandom) & N'($urandom);
            prio = {$urandom, $urandom};
            thr  = W'($urandom % 4);
            step_check("R6");
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_mask();
        t_thresh();
        t_max();
        t_tie();
        t_none();
        t_src0();
        t_zero_prio();
        t_latency();
        t_random();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule